// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block holds four 16-bit data registers. Each register can be handled as one 16-bit word, or as two separate 8-bit halves. The high half is the most significant byte of the word and the low half is the least significant byte.

Because the eight byte registers are just the halves of the four words, the two views always agree:
- Writing one byte leaves the partner byte alone.
- A word read always shows the most recent byte writes to either half.

Word register 0 and its low byte act as the accumulator for the surrounding datapath.

The file has two independent read ports and one write port. Each port carries:
- a 3-bit register index;
- a size select: 1 means word, 0 means byte.

The write port also has a write enable. Reads are purely combinational. A write takes effect at the clock edge, and there is no same-cycle bypass from the write port to the read ports. Every pin is plain control or data, with no handshake: a read is answered in the same cycle, and a write is always accepted.

Top module: `gpr_file`

## Requirements
- R1: While reset is low and after it is released, every byte of all four registers reads as zero until written.
- R2: A write with wr_en=1 and wr_wide=1 replaces the whole word selected by wr_idx[1:0] (0=AX, 1=CX, 2=DX, 3=BX) at the next clock edge. wr_idx[2] is ignored in word mode.
- R3: A write with wr_en=1 and wr_wide=0 selects the word with wr_idx[1:0] and the half with wr_idx[2] (1=high byte, 0=low byte). This gives AL=0, CL=1, DL=2, BL=3, AH=4, CH=5, DH=6, BH=7. Only that byte takes wr_data[7:0], and the partner byte keeps its value.
- R4: A word read (r*_wide=1) of index r*_idx[1:0] returns the high byte in bits 15:8 and the low byte in bits 7:0. It reflects all earlier byte writes.
- R5: A byte read (r*_wide=0) returns the selected byte in bits 7:0, with bits 15:8 at zero.
- R6: A read in the same cycle as a write to the same register returns the value held before that write. The new value appears only after the clock edge.
- R7: With wr_en=0, no register changes, whatever the other write inputs carry.
- R8: The two read ports are independent. Both may address the same or different registers, at any size, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write size: 1 word, 0 byte |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 16 | Write data (bits 7:0 used for a byte write) |
| ra_wide | input | 1 | Read port A size |
| ra_idx | input | 3 | Read port A index |
| ra_data | output | 16 | Read port A data |
| rb_wide | input | 1 | Read port B size |
| rb_idx | input | 3 | Read port B index |
| rb_data | output | 16 | Read port B data |

## Verification
The directed cases each isolate one behaviour:
- A word write through an index with bit 2 set tells word decoding apart from byte decoding.
- A high-byte write followed by reads of both halves and the word separates correct half-masking from whole-word overwrite.
- A same-cycle write and read of one register tells the no-bypass behaviour apart from a bypass.
- A write with enable low shows that disabled writes are dropped.

Random mixes of byte and word writes, with both ports reading at random sizes, then exercise every alias pairing. These mixes compare word reads that follow interleaved byte writes against a bench model.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  parameter int unsigned LANE_W    = 8;
  parameter int unsigned NUM_WORDS = 4;
  localparam int unsigned WORD_W   = 2 * LANE_W;
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS);
  localparam int unsigned IDX_W    = SEL_W + 1;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } access_size_e;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NUM_WORDS = gpr_pkg::NUM_WORDS,
  parameter int unsigned IDX_W     = gpr_pkg::IDX_W
) (
  input  logic                 wr_en,
  input  logic                 wr_wide,
  input  logic [IDX_W-1:0]     wr_idx,
  output logic [NUM_WORDS-1:0] hi_we,
  output logic [NUM_WORDS-1:0] lo_we
);
  localparam int unsigned SEL_W = IDX_W - 1;

  logic [SEL_W-1:0] word_sel;
  logic             upper_half;
  logic             full_word;

  assign word_sel   = wr_idx[SEL_W-1:0];
  assign upper_half = wr_idx[IDX_W-1];
  assign full_word  = (gpr_pkg::access_size_e'(wr_wide) == gpr_pkg::SZ_WORD);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    logic hit;
    assign hit      = wr_en && (word_sel == SEL_W'(w));
    assign hi_we[w] = hit && (full_word || upper_half);
    assign lo_we[w] = hit && (full_word || !upper_half);
  end
endmodule

// File: rtl/gpr_lane_reg.sv
module gpr_lane_reg #(
  parameter int unsigned LANE_W = gpr_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned LANE_W    = gpr_pkg::LANE_W,
  parameter int unsigned NUM_WORDS = gpr_pkg::NUM_WORDS,
  parameter int unsigned IDX_W     = gpr_pkg::IDX_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WORDS-1:0][LANE_W-1:0]    hi_q,
  input  logic [NUM_WORDS-1:0][LANE_W-1:0]    lo_q,
  input  logic                                wide,
  input  logic [IDX_W-1:0]                    idx,
  output logic [2*LANE_W-1:0]                 data
);
  localparam int unsigned SEL_W = IDX_W - 1;

  logic [SEL_W-1:0]  sel;
  logic [LANE_W-1:0] hi_b;
  logic [LANE_W-1:0] lo_b;

  assign sel  = idx[SEL_W-1:0];
  assign hi_b = hi_q[sel];
  assign lo_b = lo_q[sel];

  always_comb begin
    if (gpr_pkg::access_size_e'(wide) == gpr_pkg::SZ_WORD)
      data = {hi_b, lo_b};
    else
      data = {{LANE_W{1'b0}}, (idx[IDX_W-1] ? hi_b : lo_b)};
  end

  // R5: byte reads never leak into the upper lane
  a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> data[2*LANE_W-1:LANE_W] == '0);
  // R4: word read is the concatenation of the two stored halves
  a_r4_word_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> data == {hi_q[sel], lo_q[sel]});
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned LANE_W    = gpr_pkg::LANE_W,
  parameter int unsigned NUM_WORDS = gpr_pkg::NUM_WORDS,
  parameter int unsigned IDX_W     = gpr_pkg::IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_wide,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*LANE_W-1:0] wr_data,
  input  logic                ra_wide,
  input  logic [IDX_W-1:0]    ra_idx,
  output logic [2*LANE_W-1:0] ra_data,
  input  logic                rb_wide,
  input  logic [IDX_W-1:0]    rb_idx,
  output logic [2*LANE_W-1:0] rb_data
);
  localparam int unsigned SEL_W  = IDX_W - 1;
  localparam int unsigned WORD_W = 2 * LANE_W;

  logic [NUM_WORDS-1:0]             hi_we, lo_we;
  logic [NUM_WORDS-1:0][LANE_W-1:0] hi_q, lo_q;
  logic [LANE_W-1:0]                hi_d, lo_d;

  // Byte writes carry their data in the low lane for either half
  assign lo_d = wr_data[LANE_W-1:0];
  assign hi_d = wr_wide ? wr_data[WORD_W-1:LANE_W] : wr_data[LANE_W-1:0];

  gpr_wr_decode #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx),
    .hi_we(hi_we), .lo_we(lo_we)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    gpr_lane_reg #(.LANE_W(LANE_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .we(hi_we[w]), .d(hi_d), .q(hi_q[w])
    );
    gpr_lane_reg #(.LANE_W(LANE_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .we(lo_we[w]), .d(lo_d), .q(lo_q[w])
    );
  end

  gpr_read_port #(.LANE_W(LANE_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_rpa (
    .clk(clk), .rst_n(rst_n), .hi_q(hi_q), .lo_q(lo_q),
    .wide(ra_wide), .idx(ra_idx), .data(ra_data)
  );
  gpr_read_port #(.LANE_W(LANE_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_rpb (
    .clk(clk), .rst_n(rst_n), .hi_q(hi_q), .lo_q(lo_q),
    .wide(rb_wide), .idx(rb_idx), .data(rb_data)
  );

  // R3: at most one word selected per half
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hi_we) && $onehot0(lo_we));
  // R2: word write lands whole on the next edge
  a_r2_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_wide |=>
      {hi_q[$past(wr_idx[SEL_W-1:0])], lo_q[$past(wr_idx[SEL_W-1:0])]} == $past(wr_data));
  // R3: high-byte write leaves every low byte alone
  a_r3_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_wide && wr_idx[IDX_W-1] |=> $stable(lo_q));
  // R3: low-byte write leaves every high byte alone
  a_r3_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_wide && !wr_idx[IDX_W-1] |=> $stable(hi_q));
  // R7: disabled write changes nothing
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hi_q) && $stable(lo_q));
  // R1: first cycle out of reset sees cleared storage
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (hi_q == '0) && (lo_q == '0));
endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        ra_wide = 1'b0, rb_wide = 1'b0;
  logic [2:0]  ra_idx = '0, rb_idx = '0;
  logic [15:0] ra_data, rb_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] mdl [4];

  always #4 clk = ~clk;

  gpr_file u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_wide(ra_wide), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_wide(rb_wide), .rb_idx(rb_idx), .rb_data(rb_data)
  );

  function automatic logic [15:0] exp_rd(input logic [2:0] idx, input logic wide);
    logic [15:0] w;
    w = mdl[idx[1:0]];
    if (wide) return w;
    return idx[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic void mdl_write(input logic en, input logic wide,
                                    input logic [2:0] idx, input logic [15:0] d);
    if (!en) return;
    if (wide) mdl[idx[1:0]] = d;
    else if (idx[2]) mdl[idx[1:0]][15:8] = d[7:0];
    else mdl[idx[1:0]][7:0] = d[7:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, compare reads, then commit at the rising edge
  task automatic cyc(input logic en, input logic wide, input logic [2:0] widx,
                     input logic [15:0] d, input logic aw, input logic [2:0] ai,
                     input logic bw, input logic [2:0] bi, input string req);
    @(negedge clk);
    wr_en = en; wr_wide = wide; wr_idx = widx; wr_data = d;
    ra_wide = aw; ra_idx = ai; rb_wide = bw; rb_idx = bi;
    #1;
    chk({req, " portA"}, ra_data, exp_rd(ai, aw));
    chk({req, " portB"}, rb_data, exp_rd(bi, bw));
    @(posedge clk);
    mdl_write(en, wide, widx, d);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    // R1: reset state, all bytes and words zero, still in reset
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ra_idx = 3'(i); ra_wide = 1'b0; rb_idx = 3'(i); rb_wide = 1'b1; #1;
      chk("R1 byte", ra_data, 16'h0000);
      chk("R1 word", rb_data, 16'h0000);
    end
    @(negedge clk) rst_n = 1'b1;
    // R2: word write via index 4 targets AX (bit 2 ignored)
    cyc(1, 1, 3'd4, 16'hA55A, 1, 3'd0, 1, 3'd4, "R2");
    cyc(0, 0, 3'd0, 16'h0, 1, 3'd0, 0, 3'd4, "R2 readback");
    // R3: AH write keeps AL
    cyc(1, 0, 3'd4, 16'hFF3C, 0, 3'd0, 0, 3'd4, "R3");
    cyc(0, 0, 3'd0, 16'h0, 0, 3'd0, 0, 3'd4, "R3 halves");
    // R4: word read sees byte writes to BH and BL
    cyc(1, 0, 3'd7, 16'h0012, 1, 3'd3, 1, 3'd3, "R4");
    cyc(1, 0, 3'd3, 16'h0034, 1, 3'd3, 0, 3'd7, "R4");
    cyc(0, 0, 3'd0, 16'h0, 1, 3'd3, 1, 3'd0, "R4 word");
    // R5: byte read zero extended
    cyc(1, 1, 3'd2, 16'hFFFF, 0, 3'd6, 0, 3'd2, "R5");
    cyc(0, 0, 3'd0, 16'h0, 0, 3'd6, 0, 3'd2, "R5 upper zero");
    // R6: same-cycle write to CX, read shows old value
    cyc(1, 1, 3'd1, 16'hBEEF, 1, 3'd1, 0, 3'd5, "R6 old");
    cyc(0, 0, 3'd0, 16'h0, 1, 3'd1, 0, 3'd5, "R6 new");
    // R7: disabled write dropped
    cyc(0, 1, 3'd1, 16'h1111, 1, 3'd1, 1, 3'd1, "R7");
    cyc(0, 0, 3'd0, 16'h0, 1, 3'd1, 1, 3'd1, "R7 hold");
    // R8: random mixed traffic with both ports
    for (int n = 0; n < 3000; n++) begin
      cyc(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
          1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom), "R8 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule